// File: doc/BRIEF.md
# Load Wait Dependence Predictor

This block decides, for each load waiting in a small load tracker, whether that load may issue ahead of older stores that are still unresolved. Each store arrives as two micro-ops, one that resolves the store address and one that supplies the store data, and these can complete in either order. A load that the predictor has not flagged may issue speculatively even while older stores are outstanding. A load whose program counter maps to a set "wait" bit is held until every older store has completed both of its micro-ops.

Speculation can still go wrong. When a store address resolves to the same 8-byte block as a younger load that has already issued, the block reports an ordering violation. It squashes that load, sets the wait bit for the load's program-counter index, and replays the load once the store has completed. The wait table is a direct-mapped array of single sticky bits. The whole table is cleared at a fixed interval, so a load that stops colliding with stores is allowed to speculate again. Age comparisons use wrapping sequence numbers.

The surrounding pipeline allocates load and store slots, issues loads and frees load slots. The predictor's verdict is visible on a per-slot ready vector and on a registered violation pulse with a per-slot mask.

Top module: `ld_wait_pred`

## Requirements
- R1: After reset, every bit of `ld_ready` is 0, `viol_valid` is 0, `viol_mask` is 0 and every wait bit in the table is 0.
- R2: A load whose table index holds 0 has its `ld_ready` bit at 1 in the cycle after allocation, even while older stores are still pending.
- R3: A load whose wait bit is set is held (`ld_ready` bit 0) while any older store is missing its address op or its data op. Stores younger than the load never hold it.
- R4: A held load's `ld_ready` bit rises in the cycle after the cycle in which the last pending micro-op of its last older store is presented. The address op and the data op may arrive in either order.
- R5: A store-address op with address A raises `viol_valid` and the matching bit of `viol_mask` in the next cycle for every issued load that is younger than the store and whose issue address equals A in bits [ADDR_W-1:3]. Loads that have not issued, loads that are older than the store, and loads in a different 8-byte block do not flag.
- R6: On a violation, the table bit at index PC[7:2] of the lowest-numbered violating load is set. A later load with the same index is held, and a load with a different index is not held.
- R7: A squashed load loses its issued state and becomes wait-flagged. Its `ld_ready` bit returns to 1 once no older store is pending.
- R8: When a load is allocated in the same cycle as a violation that trains that load's index, the load takes the newly set wait bit.
- R9: All table bits are cleared once every 2^AGE_W cycles by a free-running counter. A trained load index is no longer held after the clear.
- R10: Sequence numbers are SEQ_W bits wide and wrap. A load with sequence l is younger than a store with sequence s exactly when (l - s) mod 2^SEQ_W lies in 1 .. 2^(SEQ_W-1)-1.
- R11: Issuing a load clears its `ld_ready` bit in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_alloc_valid | input | 1 | Allocate a store slot |
| st_alloc_slot | input | $clog2(SQ_DEPTH) | Store slot to allocate |
| st_alloc_seq | input | SEQ_W | Sequence number of the new store |
| st_addr_valid | input | 1 | Store-address micro-op completes |
| st_addr_slot | input | $clog2(SQ_DEPTH) | Store slot of the address op |
| st_addr | input | ADDR_W | Resolved store address |
| st_data_valid | input | 1 | Store-data micro-op completes |
| st_data_slot | input | $clog2(SQ_DEPTH) | Store slot of the data op |
| ld_alloc_valid | input | 1 | Allocate a load slot and query the table |
| ld_alloc_slot | input | $clog2(LQ_DEPTH) | Load slot to allocate |
| ld_alloc_seq | input | SEQ_W | Sequence number of the new load |
| ld_alloc_pc | input | PC_W | Program counter of the load |
| ld_issue_valid | input | 1 | Load issues to memory |
| ld_issue_slot | input | $clog2(LQ_DEPTH) | Load slot that issues |
| ld_issue_addr | input | ADDR_W | Address the load reads |
| ld_free_valid | input | 1 | Release a load slot |
| ld_free_slot | input | $clog2(LQ_DEPTH) | Load slot to release |
| ld_ready | output | LQ_DEPTH | Per-slot: allocated, not issued, and not held |
| viol_valid | output | 1 | Ordering violation detected last cycle |
| viol_mask | output | LQ_DEPTH | Load slots squashed by that violation |

## Verification
The bench sweeps every pair of 4-bit store and load sequence numbers, with store addresses that straddle an 8-byte block. A design that compared ages without wraparound, or that matched on the full address instead of the block, would flag the wrong pairs. It places a violation and a same-index load allocation in the same cycle; a table without a write-to-read bypass would let that load speculate. It completes store micro-ops in both orders and keeps a younger store pending, which catches a release one cycle early or late and a hold caused by a younger store. It also waits past the aging interval and checks that a trained index may speculate again.

// File: rtl/ldwp_pkg.sv
package ldwp_pkg;
  // Address bits below this position fall inside one 8-byte block.
  localparam int BLK_LSB = 3;
  // Table index starts above the instruction-alignment bits of the PC.
  localparam int PC_IDX_LSB = 2;

  // True when sequence a is strictly younger than b in a w-bit wrapping space.
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b,
                                       input int w);
    logic [31:0] d;
    d = (a - b) << (32 - w);
    return (d != 32'd0) && !d[31];
  endfunction
endpackage

// File: rtl/ldwp_table.sv
module ldwp_table #(
  parameter int IDX_W = 6,
  parameter int AGE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_wait,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] wait_bits;
  logic [AGE_W-1:0]   age_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_bits <= '0;
      age_cnt   <= '0;
    end else begin
      age_cnt <= age_cnt + 1'b1;
      if (age_cnt == '1) wait_bits <= '0;
      if (wr_en) wait_bits[wr_idx] <= 1'b1;
    end
  end

  // A training write in the same cycle is seen by the query.
  assign rd_wait = wait_bits[rd_idx] | (wr_en && (wr_idx == rd_idx));

  // R6
  train_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wait_bits[$past(wr_idx)]);

  // R9
  age_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (age_cnt == '1 && !wr_en) |=> (wait_bits == '0));
endmodule

// File: rtl/ldwp_stq.sv
module ldwp_stq #(
  parameter int SQ    = 4,
  parameter int SEQ_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_v,
  input  logic [$clog2(SQ)-1:0]      alloc_slot,
  input  logic [SEQ_W-1:0]           alloc_seq,
  input  logic                       addr_v,
  input  logic [$clog2(SQ)-1:0]      addr_slot,
  input  logic                       data_v,
  input  logic [$clog2(SQ)-1:0]      data_slot,
  output logic [SQ-1:0]              pend_n,
  output logic [SQ-1:0][SEQ_W-1:0]   seq_n,
  output logic [SEQ_W-1:0]           addr_seq
);
  localparam int SSW = $clog2(SQ);

  logic [SQ-1:0]            valid_q, adone_q, ddone_q;
  logic [SQ-1:0]            adone_n, ddone_n;
  logic [SQ-1:0][SEQ_W-1:0] seq_q;

  always_comb begin
    for (int i = 0; i < SQ; i++) begin
      pend_n[i]  = valid_q[i];
      adone_n[i] = adone_q[i];
      ddone_n[i] = ddone_q[i];
      seq_n[i]   = seq_q[i];
      if (alloc_v && alloc_slot == SSW'(i)) begin
        pend_n[i]  = 1'b1;
        adone_n[i] = 1'b0;
        ddone_n[i] = 1'b0;
        seq_n[i]   = alloc_seq;
      end
      if (addr_v && addr_slot == SSW'(i)) adone_n[i] = 1'b1;
      if (data_v && data_slot == SSW'(i)) ddone_n[i] = 1'b1;
      // A store retires once both of its micro-ops are done.
      if (adone_n[i] && ddone_n[i]) pend_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      adone_q <= '0;
      ddone_q <= '0;
      seq_q   <= '0;
    end else begin
      valid_q <= pend_n;
      adone_q <= adone_n;
      ddone_q <= ddone_n;
      seq_q   <= seq_n;
    end
  end

  assign addr_seq = seq_q[addr_slot];

  // R4
  for (genvar g = 0; g < SQ; g++) begin : g_chk
    st_retire_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_q[g] && adone_q[g] && data_v && data_slot == SSW'(g)
       && !(alloc_v && alloc_slot == SSW'(g))) |=> !valid_q[g]);
  end
endmodule

// File: rtl/ldwp_ldq.sv
module ldwp_ldq
  import ldwp_pkg::*;
#(
  parameter int LQ     = 4,
  parameter int SQ     = 4,
  parameter int SEQ_W  = 4,
  parameter int BLK_W  = 13,
  parameter int IDX_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_v,
  input  logic [$clog2(LQ)-1:0]      alloc_slot,
  input  logic [SEQ_W-1:0]           alloc_seq,
  input  logic [IDX_W-1:0]           alloc_idx,
  input  logic                       alloc_wait,
  input  logic                       issue_v,
  input  logic [$clog2(LQ)-1:0]      issue_slot,
  input  logic [BLK_W-1:0]           issue_blk,
  input  logic                       free_v,
  input  logic [$clog2(LQ)-1:0]      free_slot,
  input  logic                       st_addr_v,
  input  logic [BLK_W-1:0]           st_addr_blk,
  input  logic [SEQ_W-1:0]           st_addr_seq,
  input  logic [SQ-1:0]              st_pend_n,
  input  logic [SQ-1:0][SEQ_W-1:0]   st_seq_n,
  output logic                       train_en,
  output logic [IDX_W-1:0]           train_idx,
  output logic [LQ-1:0]              ready_q,
  output logic                       viol_v,
  output logic [LQ-1:0]              viol_mask
);
  localparam int LSW = $clog2(LQ);

  logic [LQ-1:0]             valid_q, issued_q, wait_q;
  logic [LQ-1:0]             valid_n, issued_n, wait_n, ready_n, hit;
  logic [LQ-1:0][SEQ_W-1:0]  seq_q, seq_n;
  logic [LQ-1:0][IDX_W-1:0]  idx_q, idx_n;
  logic [LQ-1:0][BLK_W-1:0]  blk_q, blk_n;

  // Ordering check against the store address resolving this cycle.
  always_comb begin
    train_en  = 1'b0;
    train_idx = '0;
    for (int i = LQ - 1; i >= 0; i--) begin
      hit[i] = valid_q[i] && issued_q[i] && st_addr_v
               && (blk_q[i] == st_addr_blk)
               && seq_younger(32'(seq_q[i]), 32'(st_addr_seq), SEQ_W);
      if (hit[i]) begin
        train_en  = 1'b1;
        train_idx = idx_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LQ; i++) begin
      valid_n[i]  = valid_q[i];
      issued_n[i] = issued_q[i];
      wait_n[i]   = wait_q[i];
      seq_n[i]    = seq_q[i];
      idx_n[i]    = idx_q[i];
      blk_n[i]    = blk_q[i];
      if (alloc_v && alloc_slot == LSW'(i)) begin
        valid_n[i]  = 1'b1;
        issued_n[i] = 1'b0;
        wait_n[i]   = alloc_wait;
        seq_n[i]    = alloc_seq;
        idx_n[i]    = alloc_idx;
      end
      if (issue_v && issue_slot == LSW'(i)) begin
        issued_n[i] = 1'b1;
        blk_n[i]    = issue_blk;
      end
      if (hit[i]) begin
        issued_n[i] = 1'b0;
        wait_n[i]   = 1'b1;
      end
      if (free_v && free_slot == LSW'(i)) valid_n[i] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < LQ; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < SQ; j++) begin
        if (st_pend_n[j] && seq_younger(32'(seq_n[i]), 32'(st_seq_n[j]), SEQ_W))
          blocked = 1'b1;
      end
      ready_n[i] = valid_n[i] && !issued_n[i] && !(wait_n[i] && blocked);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      issued_q  <= '0;
      wait_q    <= '0;
      seq_q     <= '0;
      idx_q     <= '0;
      blk_q     <= '0;
      ready_q   <= '0;
      viol_v    <= 1'b0;
      viol_mask <= '0;
    end else begin
      valid_q   <= valid_n;
      issued_q  <= issued_n;
      wait_q    <= wait_n;
      seq_q     <= seq_n;
      idx_q     <= idx_n;
      blk_q     <= blk_n;
      ready_q   <= ready_n;
      viol_v    <= |hit;
      viol_mask <= hit;
    end
  end

  for (genvar g = 0; g < LQ; g++) begin : g_chk
    // R11
    issue_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_v && issue_slot == LSW'(g)) |=> !ready_q[g]);
    // R5
    viol_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
      viol_mask[g] |-> $past(issued_q[g]));
  end
endmodule

// File: rtl/ld_wait_pred.sv
module ld_wait_pred
  import ldwp_pkg::*;
#(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int SEQ_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int PC_W     = 16,
  parameter int IDX_W    = 6,
  parameter int AGE_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        st_alloc_valid,
  input  logic [$clog2(SQ_DEPTH)-1:0] st_alloc_slot,
  input  logic [SEQ_W-1:0]            st_alloc_seq,
  input  logic                        st_addr_valid,
  input  logic [$clog2(SQ_DEPTH)-1:0] st_addr_slot,
  input  logic [ADDR_W-1:0]           st_addr,
  input  logic                        st_data_valid,
  input  logic [$clog2(SQ_DEPTH)-1:0] st_data_slot,
  input  logic                        ld_alloc_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0] ld_alloc_slot,
  input  logic [SEQ_W-1:0]            ld_alloc_seq,
  input  logic [PC_W-1:0]             ld_alloc_pc,
  input  logic                        ld_issue_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0] ld_issue_slot,
  input  logic [ADDR_W-1:0]           ld_issue_addr,
  input  logic                        ld_free_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0] ld_free_slot,
  output logic [LQ_DEPTH-1:0]         ld_ready,
  output logic                        viol_valid,
  output logic [LQ_DEPTH-1:0]         viol_mask
);
  localparam int BLK_W   = ADDR_W - BLK_LSB;
  localparam int IDX_MSB = PC_IDX_LSB + IDX_W - 1;

  logic [SQ_DEPTH-1:0]            st_pend_n;
  logic [SQ_DEPTH-1:0][SEQ_W-1:0] st_seq_n;
  logic [SEQ_W-1:0]               st_addr_seq;
  logic                           train_en, pred_wait;
  logic [IDX_W-1:0]               train_idx, query_idx;

  // Bits outside the block index and the table index carry no information here.
  logic unused_bits;
  assign unused_bits = ^{st_addr[BLK_LSB-1:0], ld_issue_addr[BLK_LSB-1:0],
                         ld_alloc_pc[PC_W-1:IDX_MSB+1], ld_alloc_pc[PC_IDX_LSB-1:0]};

  assign query_idx = ld_alloc_pc[IDX_MSB:PC_IDX_LSB];

  ldwp_table #(.IDX_W(IDX_W), .AGE_W(AGE_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (query_idx),
    .rd_wait (pred_wait),
    .wr_en   (train_en),
    .wr_idx  (train_idx)
  );

  ldwp_stq #(.SQ(SQ_DEPTH), .SEQ_W(SEQ_W)) u_stq (
    .clk        (clk),
    .rst        (rst),
    .alloc_v    (st_alloc_valid),
    .alloc_slot (st_alloc_slot),
    .alloc_seq  (st_alloc_seq),
    .addr_v     (st_addr_valid),
    .addr_slot  (st_addr_slot),
    .data_v     (st_data_valid),
    .data_slot  (st_data_slot),
    .pend_n     (st_pend_n),
    .seq_n      (st_seq_n),
    .addr_seq   (st_addr_seq)
  );

  ldwp_ldq #(.LQ(LQ_DEPTH), .SQ(SQ_DEPTH), .SEQ_W(SEQ_W), .BLK_W(BLK_W),
             .IDX_W(IDX_W)) u_ldq (
    .clk         (clk),
    .rst         (rst),
    .alloc_v     (ld_alloc_valid),
    .alloc_slot  (ld_alloc_slot),
    .alloc_seq   (ld_alloc_seq),
    .alloc_idx   (query_idx),
    .alloc_wait  (pred_wait),
    .issue_v     (ld_issue_valid),
    .issue_slot  (ld_issue_slot),
    .issue_blk   (ld_issue_addr[ADDR_W-1:BLK_LSB]),
    .free_v      (ld_free_valid),
    .free_slot   (ld_free_slot),
    .st_addr_v   (st_addr_valid),
    .st_addr_blk (st_addr[ADDR_W-1:BLK_LSB]),
    .st_addr_seq (st_addr_seq),
    .st_pend_n   (st_pend_n),
    .st_seq_n    (st_seq_n),
    .train_en    (train_en),
    .train_idx   (train_idx),
    .ready_q     (ld_ready),
    .viol_v      (viol_valid),
    .viol_mask   (viol_mask)
  );
endmodule

// File: tb/ld_wait_pred_tb.sv
`timescale 1ns/1ps
module ld_wait_pred_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       st_alloc_valid = 0, st_addr_valid = 0, st_data_valid = 0;
  logic [1:0] st_alloc_slot = 0, st_addr_slot = 0, st_data_slot = 0;
  logic [3:0] st_alloc_seq = 0, ld_alloc_seq = 0;
  logic [15:0] st_addr = 0, ld_alloc_pc = 0, ld_issue_addr = 0;
  logic       ld_alloc_valid = 0, ld_issue_valid = 0, ld_free_valid = 0;
  logic [1:0] ld_alloc_slot = 0, ld_issue_slot = 0, ld_free_slot = 0;
  logic [3:0] ld_ready, viol_mask;
  logic       viol_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  ld_wait_pred u_dut (
    .clk(clk), .rst(rst),
    .st_alloc_valid(st_alloc_valid), .st_alloc_slot(st_alloc_slot), .st_alloc_seq(st_alloc_seq),
    .st_addr_valid(st_addr_valid), .st_addr_slot(st_addr_slot), .st_addr(st_addr),
    .st_data_valid(st_data_valid), .st_data_slot(st_data_slot),
    .ld_alloc_valid(ld_alloc_valid), .ld_alloc_slot(ld_alloc_slot), .ld_alloc_seq(ld_alloc_seq),
    .ld_alloc_pc(ld_alloc_pc),
    .ld_issue_valid(ld_issue_valid), .ld_issue_slot(ld_issue_slot), .ld_issue_addr(ld_issue_addr),
    .ld_free_valid(ld_free_valid), .ld_free_slot(ld_free_slot),
    .ld_ready(ld_ready), .viol_valid(viol_valid), .viol_mask(viol_mask)
  );

  // Advance one edge; inputs are driven and outputs sampled 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic st_alloc(input logic [1:0] s, input logic [3:0] q);
    st_alloc_valid = 1; st_alloc_slot = s; st_alloc_seq = q;
    tick(); st_alloc_valid = 0;
  endtask
  task automatic st_addr_op(input logic [1:0] s, input logic [15:0] a);
    st_addr_valid = 1; st_addr_slot = s; st_addr = a;
    tick(); st_addr_valid = 0;
  endtask
  task automatic st_data_op(input logic [1:0] s);
    st_data_valid = 1; st_data_slot = s;
    tick(); st_data_valid = 0;
  endtask
  task automatic ld_alloc(input logic [1:0] s, input logic [3:0] q, input logic [15:0] pc);
    ld_alloc_valid = 1; ld_alloc_slot = s; ld_alloc_seq = q; ld_alloc_pc = pc;
    tick(); ld_alloc_valid = 0;
  endtask
  task automatic ld_issue(input logic [1:0] s, input logic [15:0] a);
    ld_issue_valid = 1; ld_issue_slot = s; ld_issue_addr = a;
    tick(); ld_issue_valid = 0;
  endtask
  task automatic ld_free(input logic [1:0] s);
    ld_free_valid = 1; ld_free_slot = s;
    tick(); ld_free_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 ready", 32'(ld_ready), 0);
    chk("R1 viol", 32'(viol_valid), 0);

    // R2 unflagged load speculates past an older pending store
    st_alloc(0, 1);
    ld_alloc(0, 2, 16'h0124);
    chk("R2 spec ready", 32'(ld_ready[0]), 1);
    ld_issue(0, 16'h0040);
    chk("R11 issue clears ready", 32'(ld_ready[0]), 0);
    st_data_op(0);
    st_addr_op(0, 16'h0044);
    chk("R5 viol same block", 32'(viol_valid), 1);
    chk("R5 viol mask", 32'(viol_mask), 32'h1);
    chk("R7 replay ready", 32'(ld_ready[0]), 1);
    tick();
    chk("R5 viol one cycle", 32'(viol_valid), 0);
    ld_free(0);

    // R6 training: same index held, other index not
    st_alloc(1, 3);
    ld_alloc(1, 4, 16'h0224);
    chk("R6 trained index held", 32'(ld_ready[1]), 0);
    ld_alloc(2, 5, 16'h0128);
    chk("R6 other index free", 32'(ld_ready[2]), 1);
    st_alloc(2, 6);
    st_addr_op(1, 16'h0800);
    chk("R5 no viol unissued", 32'(viol_valid), 0);
    chk("R4 held until data op", 32'(ld_ready[1]), 0);
    st_data_op(1);
    chk("R4 release after last op", 32'(ld_ready[1]), 1);
    chk("R3 younger store no hold", 32'(ld_ready[1]), 1);
    st_addr_op(2, 16'h0900);
    st_data_op(2);
    ld_free(1);
    ld_free(2);

    // R8 violation and same-index allocation in one cycle
    st_alloc(0, 7);
    st_data_op(0);
    ld_alloc(0, 8, 16'h0050);
    ld_issue(0, 16'h0100);
    st_alloc(1, 9);
    st_addr_valid = 1; st_addr_slot = 0; st_addr = 16'h0104;
    ld_alloc_valid = 1; ld_alloc_slot = 1; ld_alloc_seq = 10; ld_alloc_pc = 16'h0150;
    tick();
    st_addr_valid = 0; ld_alloc_valid = 0;
    chk("R8 viol", 32'(viol_mask), 32'h1);
    chk("R8 bypass holds new load", 32'(ld_ready[1]), 0);
    chk("R7 squashed load replays", 32'(ld_ready[0]), 1);
    st_addr_op(1, 16'h0900);
    chk("R3 held on addr only", 32'(ld_ready[1]), 0);
    st_data_op(1);
    chk("R4 release", 32'(ld_ready[1]), 1);
    ld_free(0);
    ld_free(1);

    // R9 aging clears the trained index 9
    repeat (4200) tick();
    st_alloc(0, 1);
    ld_alloc(0, 2, 16'h0224);
    chk("R9 aged entry speculates", 32'(ld_ready[0]), 1);
    st_addr_op(0, 16'h0a00);
    st_data_op(0);
    ld_free(0);

    // R10 / R5 sweep over every sequence pair and block offsets
    for (int s = 0; s < 16; s++) begin
      for (int l = 0; l < 16; l++) begin
        int k;
        int d;
        bit exp;
        k = (s * 16 + l) % 24;
        d = (l - s) & 15;
        exp = (d != 0) && (d < 8) && (k >= 8) && (k < 16);
        st_alloc(0, 4'(s));
        st_data_op(0);
        ld_alloc(0, 4'(l), 16'h0300);
        ld_issue(0, 16'h0200);
        st_addr_op(0, 16'h01F8 + 16'(k));
        chk("R10 wrap age and block match", 32'(viol_valid), 32'(exp));
        ld_free(0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule